// File: doc/BRIEF.md
# UART receive FIFO status controller

This block sits behind a UART's bit-level receiver and handles everything that happens to a character once it has been deserialized. Each character arrives with a single-cycle valid strobe carrying eight data bits and three error flags: received break, framing error and parity error. The character goes into a four-entry FIFO, and the data and flags are kept together in each entry. A character that arrives while the FIFO is full is dropped and sets an overrun flag. Reading the data port pops the head entry.

The block reports status for the received characters. The break, framing and parity status bits can follow the character at the head of the FIFO. They can also collect, as sticky bits, the flags of every character that has reached the head since the last error-reset command. The block raises an interrupt/DMA request from either "data ready" or "FIFO full". It can also drive a request-to-send output that holds off the remote transmitter when a new start bit is seen while there is no room.

Two 8-bit mode registers share one access port. A pointer selects between them. The pointer moves to the second register after any access to the first. A separate command sends it back to the first.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the FIFO is empty (`rxRdy`=0, `fifoFull`=0), `irqReq`=0, `overrun`=0, `rtsOut`=1, all status flags are 0, both mode registers hold 0x00, and the pointer selects mode register 1.
- R2: `modeRdData` shows the register the pointer selects, and `modeWrEn` writes that register. Any read or write while the pointer is on mode register 1 moves it to mode register 2, where it stays. `cmdRstPtr` returns the pointer to mode register 1 on the next cycle.
- R3: The FIFO holds 4 characters in arrival order, and `rxData` shows the head. `rxRdy` (not empty) and `fifoFull` change in the cycle after the push or pop that causes the change. `dataRdEn` pops only when `rxRdy` is 1.
- R4: With mode register 1 bit 7 (receiver RTS enable) at 0, `rtsOut` stays 1 whatever the FIFO and start-bit activity.
- R5: With bit 7 of mode register 1 at 1 and bit 5 of mode register 2 at 0, a `startBit` pulse while `fifoFull`=1 drives `rtsOut` to 0 from the next cycle. `rtsOut` returns to 1 in the same cycle that `fifoFull` falls. A full FIFO with no start bit leaves `rtsOut` at 1.
- R6: When bit 7 of mode register 1 and bit 5 of mode register 2 (transmitter RTS enable) are both 1, receiver RTS control is off and `rtsOut` stays 1.
- R7: Mode register 1 bit 6 selects the request source: 0 gives `irqReq` = `rxRdy`, and 1 gives `irqReq` = `fifoFull`.
- R8: With mode register 1 bit 5 at 0 (per-character mode), `statBreak`/`statFrameErr`/`statParityErr` show the flags stored with the current head character, and they read 0 when the FIFO is empty.
- R9: A character presented while `fifoFull`=1 is discarded, and `overrun` is set from the next cycle. The four stored characters remain unchanged.
- R10: With mode register 1 bit 5 at 1 (block mode), each status bit is the OR of that flag over every character that has become the head since the last `cmdRstErr`.
- R11: `cmdRstErr` clears the block-mode accumulators and `overrun` for the next cycle. Flags of a character that becomes the head in the same cycle are still captured, and a new overrun in that cycle also wins over the clear.
- R12: Mode register 1 fields sit at these positions: bit 7 receiver RTS enable, bit 6 request select, bit 5 error mode, bits 4:3 parity mode, bit 2 parity type, bits 1:0 bits per character. The parity and width fields go out on `cfgParityMode`, `cfgParityOdd` and `cfgCharBits`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| charValid | input | 1 | One-cycle strobe: a received character is present |
| startBit | input | 1 | One-cycle strobe: a valid start bit was detected |
| charData | input | 8 | Received character data |
| charBreak | input | 1 | Character flag: received break |
| charFrameErr | input | 1 | Character flag: framing error |
| charParityErr | input | 1 | Character flag: parity error |
| dataRdEn | input | 1 | Read strobe for the data port, pops the head |
| rxData | output | 8 | Data of the head character |
| modeWrEn | input | 1 | Write strobe for the mode register the pointer selects |
| modeRdEn | input | 1 | Read strobe for the mode register the pointer selects |
| modeWrData | input | 8 | Mode register write data |
| modeRdData | output | 8 | Contents of the mode register the pointer selects |
| cmdRstPtr | input | 1 | Command: point back to mode register 1 |
| cmdRstErr | input | 1 | Command: clear the error accumulators and overrun |
| rxRdy | output | 1 | FIFO not empty |
| fifoFull | output | 1 | FIFO holds 4 characters |
| statBreak | output | 1 | Break status |
| statFrameErr | output | 1 | Framing error status |
| statParityErr | output | 1 | Parity error status |
| overrun | output | 1 | Sticky: a character was dropped |
| irqReq | output | 1 | Interrupt/DMA request |
| rtsOut | output | 1 | Request-to-send, 1 = asserted |
| cfgParityMode | output | 2 | Parity mode field |
| cfgParityOdd | output | 1 | Parity type field |
| cfgCharBits | output | 2 | Bits-per-character field |

## Verification
Characters are pushed with flags that differ from one entry to the next, for example framing error on one and parity error on the next. This separates a status that follows the head from one that accumulates, and it catches flags paired with the wrong entry. Filling the FIFO and then offering a fifth character shows whether the overflow is dropped without disturbing the stored order. The start-bit test is run with the FIFO full and with it not full, under each combination of receiver and transmitter RTS enables, so that the drop, the release and the mutual-disable rule are each seen on their own. A pop and an error reset are issued in the same cycle to show that the new head's flags survive the clear.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  // Error flags stored alongside each character
  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxErr_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic clrErr;
    logic ovrEvt;
  } rxStrb_t;

  // Mode register 1 field positions
  localparam int M1_RXRTS   = 7;
  localparam int M1_IRQSEL  = 6;
  localparam int M1_ERRMODE = 5;
  localparam int M1_PM_HI   = 4;
  localparam int M1_PM_LO   = 3;
  localparam int M1_PT      = 2;
  localparam int M1_BC_HI   = 1;
  localparam int M1_BC_LO   = 0;
  // Mode register 2: transmitter RTS enable
  localparam int M2_TXRTS   = 5;

endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          charValid,
  input  logic          startBit,
  input  logic          dataRdEn,
  input  logic          modeWrEn,
  input  logic          modeRdEn,
  input  logic [MW-1:0] modeWrData,
  input  logic          cmdRstPtr,
  input  logic          cmdRstErr,
  input  logic          rxRdy,
  input  logic          fifoFull,
  output rxStrb_t       strb,
  output logic [MW-1:0] mode1,
  output logic [MW-1:0] mode2,
  output logic          modePtr,
  output logic [MW-1:0] modeRdData,
  output logic          rtsOut,
  output logic          irqReq
);

  logic modeAccess;
  logic rtsCtrlOn;
  logic rtsHold;

  // Character flow strobes
  always_comb begin
    strb.push   = charValid & ~fifoFull;
    strb.ovrEvt = charValid & fifoFull;
    strb.pop    = dataRdEn & rxRdy;
    strb.clrErr = cmdRstErr;
  end

  // Mode register pair behind one pointer (0 = register 1)
  assign modeAccess = modeWrEn | modeRdEn;
  assign modeRdData = modePtr ? mode2 : mode1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modePtr <= 1'b0;
      mode1   <= '0;
      mode2   <= '0;
    end else begin
      if (modeWrEn) begin
        if (modePtr) mode2 <= modeWrData;
        else         mode1 <= modeWrData;
      end
      if (cmdRstPtr)       modePtr <= 1'b0;
      else if (modeAccess) modePtr <= 1'b1;
    end
  end

  // Receiver flow control: both enables set cancels each other
  assign rtsCtrlOn = mode1[M1_RXRTS] & ~mode2[M2_TXRTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtsHold <= 1'b0;
    else       rtsHold <= rtsCtrlOn & fifoFull & (startBit | rtsHold);
  end

  assign rtsOut = ~(rtsHold & fifoFull & rtsCtrlOn);

  // Request source select
  assign irqReq = mode1[M1_IRQSEL] ? fifoFull : rxRdy;

endmodule

// File: rtl/uart_rx_dp.sv
module uart_rx_dp
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxStrb_t       strb,
  input  logic [DW-1:0] charData,
  input  rxErr_t        charErr,
  input  logic          errMode,
  output logic [DW-1:0] rxData,
  output logic          rxRdy,
  output logic          fifoFull,
  output rxErr_t        statErr,
  output logic          overrun
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] dataMem [DEPTH];
  rxErr_t        errMem  [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, rdNext, wrNext;
  logic [CW-1:0] count;
  rxErr_t        headErr, arriveErr, errAcc;

  // Pointer increment: free wrap for powers of two, compare otherwise
  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrapPow2
      assign rdNext = rdPtr + 1'b1;
      assign wrNext = wrPtr + 1'b1;
    end else begin : g_wrapCmp
      assign rdNext = (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      assign wrNext = (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        dataMem[i] <= '0;
        errMem[i]  <= '0;
      end
    end else if (strb.push) begin
      dataMem[wrPtr] <= charData;
      errMem[wrPtr]  <= charErr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= wrNext;
      if (strb.pop)  rdPtr <= rdNext;
      count <= count + CW'(strb.push) - CW'(strb.pop);
    end
  end

  assign rxRdy    = (count != '0);
  assign fifoFull = (count == CW'(DEPTH));
  assign rxData   = dataMem[rdPtr];
  assign headErr  = rxRdy ? errMem[rdPtr] : '0;

  // Flags of the character that becomes the head this cycle
  always_comb begin
    arriveErr = '0;
    if (strb.pop && count > CW'(1))
      arriveErr = errMem[rdNext];
    else if (strb.push && (count == '0 || (strb.pop && count == CW'(1))))
      arriveErr = charErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAcc  <= '0;
      overrun <= 1'b0;
    end else begin
      errAcc  <= (strb.clrErr ? rxErr_t'('0) : errAcc) | arriveErr;
      overrun <= (strb.clrErr ? 1'b0 : overrun) | strb.ovrEvt;
    end
  end

  assign statErr = errMode ? errAcc : headErr;

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          charValid,
  input  logic          startBit,
  input  logic [DW-1:0] charData,
  input  logic          charBreak,
  input  logic          charFrameErr,
  input  logic          charParityErr,
  input  logic          dataRdEn,
  output logic [DW-1:0] rxData,
  input  logic          modeWrEn,
  input  logic          modeRdEn,
  input  logic [7:0]    modeWrData,
  output logic [7:0]    modeRdData,
  input  logic          cmdRstPtr,
  input  logic          cmdRstErr,
  output logic          rxRdy,
  output logic          fifoFull,
  output logic          statBreak,
  output logic          statFrameErr,
  output logic          statParityErr,
  output logic          overrun,
  output logic          irqReq,
  output logic          rtsOut,
  output logic [1:0]    cfgParityMode,
  output logic          cfgParityOdd,
  output logic [1:0]    cfgCharBits
);

  rxStrb_t    strb;
  rxErr_t     charErr, statErr;
  logic [7:0] mode1, mode2;
  logic       modePtr;

  assign charErr = '{brk: charBreak, frm: charFrameErr, par: charParityErr};

  uart_rx_ctrl #(.MW(8)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .charValid(charValid), .startBit(startBit), .dataRdEn(dataRdEn),
    .modeWrEn(modeWrEn), .modeRdEn(modeRdEn), .modeWrData(modeWrData),
    .cmdRstPtr(cmdRstPtr), .cmdRstErr(cmdRstErr),
    .rxRdy(rxRdy), .fifoFull(fifoFull),
    .strb(strb), .mode1(mode1), .mode2(mode2), .modePtr(modePtr),
    .modeRdData(modeRdData), .rtsOut(rtsOut), .irqReq(irqReq)
  );

  uart_rx_dp #(.DEPTH(DEPTH), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .charData(charData), .charErr(charErr), .errMode(mode1[M1_ERRMODE]),
    .rxData(rxData), .rxRdy(rxRdy), .fifoFull(fifoFull),
    .statErr(statErr), .overrun(overrun)
  );

  assign statBreak     = statErr.brk;
  assign statFrameErr  = statErr.frm;
  assign statParityErr = statErr.par;
  assign cfgParityMode = mode1[M1_PM_HI:M1_PM_LO];
  assign cfgParityOdd  = mode1[M1_PT];
  assign cfgCharBits   = mode1[M1_BC_HI:M1_BC_LO];

endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk (
  input logic clk,
  input logic rstN,
  input logic charValid,
  input logic startBit,
  input logic dataRdEn,
  input logic modeWrEn,
  input logic modeRdEn,
  input logic cmdRstPtr,
  input logic rxRdy,
  input logic fifoFull,
  input logic overrun,
  input logic irqReq,
  input logic rtsOut,
  input logic modePtr,
  input logic rxRtsEn,
  input logic txRtsEn
);

  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn || modeRdEn) && !cmdRstPtr |=> modePtr); // R2
  AST_PTR_RESET: assert property (@(posedge clk) disable iff (!rstN)
    cmdRstPtr |=> !modePtr); // R2
  AST_RDY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    charValid && !fifoFull |=> rxRdy); // R3
  AST_FULL_IMPLIES_RDY: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> rxRdy); // R3
  AST_RTS_PASSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !rxRtsEn |-> rtsOut); // R4
  AST_RTS_DROP: assert property (@(posedge clk) disable iff (!rstN)
    rxRtsEn && !txRtsEn && startBit && fifoFull && !dataRdEn && !modeWrEn |=> !rtsOut); // R5
  AST_RTS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    !fifoFull |-> rtsOut); // R5
  AST_RTS_BOTH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    rxRtsEn && txRtsEn |-> rtsOut); // R6
  AST_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    !rxRdy |-> !irqReq); // R7
  AST_IRQ_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> irqReq); // R7
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    charValid && fifoFull |=> overrun); // R9

endmodule

bind uart_rx_status uart_rx_status_chk u_chk (
  .clk(clk), .rstN(rstN), .charValid(charValid), .startBit(startBit),
  .dataRdEn(dataRdEn), .modeWrEn(modeWrEn), .modeRdEn(modeRdEn),
  .cmdRstPtr(cmdRstPtr), .rxRdy(rxRdy), .fifoFull(fifoFull),
  .overrun(overrun), .irqReq(irqReq), .rtsOut(rtsOut), .modePtr(modePtr),
  .rxRtsEn(mode1[7]), .txRtsEn(mode2[5])
);

// File: tb/sim_uart_rx_status.sv
module sim_uart_rx_status;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       charValid = 0, startBit = 0, dataRdEn = 0;
  logic [7:0] charData = '0;
  logic       charBreak = 0, charFrameErr = 0, charParityErr = 0;
  logic       modeWrEn = 0, modeRdEn = 0, cmdRstPtr = 0, cmdRstErr = 0;
  logic [7:0] modeWrData = '0;
  logic [7:0] rxData, modeRdData;
  logic       rxRdy, fifoFull, statBreak, statFrameErr, statParityErr;
  logic       overrun, irqReq, rtsOut, cfgParityOdd;
  logic [1:0] cfgParityMode, cfgCharBits;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_rx_status u0 (
    .clk(clk), .rstN(rstN), .charValid(charValid), .startBit(startBit),
    .charData(charData), .charBreak(charBreak), .charFrameErr(charFrameErr),
    .charParityErr(charParityErr), .dataRdEn(dataRdEn), .rxData(rxData),
    .modeWrEn(modeWrEn), .modeRdEn(modeRdEn), .modeWrData(modeWrData),
    .modeRdData(modeRdData), .cmdRstPtr(cmdRstPtr), .cmdRstErr(cmdRstErr),
    .rxRdy(rxRdy), .fifoFull(fifoFull), .statBreak(statBreak),
    .statFrameErr(statFrameErr), .statParityErr(statParityErr),
    .overrun(overrun), .irqReq(irqReq), .rtsOut(rtsOut),
    .cfgParityMode(cfgParityMode), .cfgParityOdd(cfgParityOdd),
    .cfgCharBits(cfgCharBits)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int statVec();
    return {29'd0, statBreak, statFrameErr, statParityErr};
  endfunction

  // All stimulus tasks start and end just after a falling edge
  task automatic pushC(input logic [7:0] d, input logic [2:0] e);
    charValid = 1; charData = d; {charBreak, charFrameErr, charParityErr} = e;
    @(negedge clk);
    charValid = 0; {charBreak, charFrameErr, charParityErr} = 3'b000;
  endtask

  task automatic popC();
    dataRdEn = 1; @(negedge clk); dataRdEn = 0;
  endtask

  task automatic pulseStart();
    startBit = 1; @(negedge clk); startBit = 0;
  endtask

  task automatic wrMode(input logic [7:0] v);
    modeWrEn = 1; modeWrData = v; @(negedge clk); modeWrEn = 0;
  endtask

  task automatic rdMode(output logic [7:0] v);
    v = modeRdData; modeRdEn = 1; @(negedge clk); modeRdEn = 0;
  endtask

  task automatic rstPtr();
    cmdRstPtr = 1; @(negedge clk); cmdRstPtr = 0;
  endtask

  task automatic rstErr();
    cmdRstErr = 1; @(negedge clk); cmdRstErr = 0;
  endtask

  task automatic setMr1(input logic [7:0] v);
    rstPtr(); wrMode(v);
  endtask

  task automatic setMr2(input logic [7:0] v);
    logic [7:0] dummy;
    rstPtr(); rdMode(dummy); wrMode(v);
  endtask

  task automatic flush();
    for (int i = 0; i < 8 && rxRdy; i++) popC();
    rstErr();
  endtask

  task automatic testReset();
    chk("R1", "rxRdy", rxRdy, 0);
    chk("R1", "fifoFull", fifoFull, 0);
    chk("R1", "irqReq", irqReq, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "rtsOut", rtsOut, 1);
    chk("R1", "status", statVec(), 0);
    chk("R1", "mode1 readback", modeRdData, 8'h00);
  endtask

  task automatic testPointer();
    logic [7:0] v;
    wrMode(8'hA5);
    rdMode(v); chk("R2", "mode2 after mode1 write", v, 8'h00);
    wrMode(8'h3C);
    rdMode(v); chk("R2", "mode2 stays selected", v, 8'h3C);
    rstPtr();
    rdMode(v); chk("R2", "mode1 after pointer reset", v, 8'hA5);
    // R12: A5 = rts1 irq0 err1 pm 00 pt1 bc 01
    chk("R12", "parity mode", cfgParityMode, 2'b00);
    chk("R12", "parity type", cfgParityOdd, 1);
    chk("R12", "char bits", cfgCharBits, 2'b01);
    rdMode(v); chk("R2", "mode2 after mode1 read", v, 8'h3C);
    setMr1(8'h1A);
    chk("R12", "parity mode 1A", cfgParityMode, 2'b11);
    chk("R12", "char bits 1A", cfgCharBits, 2'b10);
    setMr1(8'h00); setMr2(8'h00);
  endtask

  task automatic testFifo();
    pushC(8'h11, 3'b000);
    chk("R3", "rxRdy after push", rxRdy, 1);
    chk("R3", "head data", rxData, 8'h11);
    pushC(8'h22, 3'b000); pushC(8'h33, 3'b000);
    chk("R3", "not full at 3", fifoFull, 0);
    pushC(8'h44, 3'b000);
    chk("R3", "full at 4", fifoFull, 1);
    popC();
    chk("R3", "full clears after pop", fifoFull, 0);
    chk("R3", "second data", rxData, 8'h22);
    popC(); chk("R3", "third data", rxData, 8'h33);
    popC(); chk("R3", "fourth data", rxData, 8'h44);
    chk("R3", "rxRdy with one left", rxRdy, 1);
    popC(); chk("R3", "empty after last pop", rxRdy, 0);
    popC(); chk("R3", "pop on empty ignored", rxRdy, 0);
    chk("R3", "pop on empty keeps not full", fifoFull, 0);
  endtask

  task automatic testOverrun();
    pushC(8'hA1, 3'b000); pushC(8'hA2, 3'b000);
    pushC(8'hA3, 3'b000); pushC(8'hA4, 3'b000);
    chk("R9", "no overrun at full", overrun, 0);
    pushC(8'hA5, 3'b111);
    chk("R9", "overrun set", overrun, 1);
    chk("R9", "still full", fifoFull, 1);
    chk("R9", "head kept", rxData, 8'hA1);
    popC(); chk("R9", "entry 2", rxData, 8'hA2);
    popC(); chk("R9", "entry 3", rxData, 8'hA3);
    popC(); chk("R9", "entry 4", rxData, 8'hA4);
    popC(); chk("R9", "dropped char not stored", rxRdy, 0);
    chk("R9", "overrun sticky", overrun, 1);
    rstErr();
    chk("R11", "overrun cleared", overrun, 0);
  endtask

  task automatic testIrq();
    setMr1(8'h00);
    pushC(8'h01, 3'b000);
    chk("R7", "irq from ready", irqReq, 1);
    flush();
    chk("R7", "irq low when empty", irqReq, 0);
    setMr1(8'h40);
    pushC(8'h01, 3'b000); pushC(8'h02, 3'b000); pushC(8'h03, 3'b000);
    chk("R7", "full-select irq low at 3", irqReq, 0);
    pushC(8'h04, 3'b000);
    chk("R7", "full-select irq high at 4", irqReq, 1);
    popC();
    chk("R7", "full-select irq low after pop", irqReq, 0);
    flush(); setMr1(8'h00);
  endtask

  task automatic testCharMode();
    pushC(8'h51, 3'b010);
    pushC(8'h52, 3'b001);
    chk("R8", "head framing flag", statVec(), 3'b010);
    popC();
    chk("R8", "head parity flag", statVec(), 3'b001);
    popC();
    chk("R8", "empty status zero", statVec(), 3'b000);
  endtask

  task automatic testBlockMode();
    setMr1(8'h20); rstErr();
    pushC(8'h61, 3'b010);
    chk("R10", "first head flags", statVec(), 3'b010);
    pushC(8'h62, 3'b001);
    chk("R10", "non-head not counted", statVec(), 3'b010);
    pushC(8'h63, 3'b000);
    popC();
    chk("R10", "accumulated or", statVec(), 3'b011);
    popC();
    chk("R10", "sticky after clean head", statVec(), 3'b011);
    rstErr();
    chk("R11", "accumulator cleared", statVec(), 3'b000);
    popC();
    pushC(8'h71, 3'b000); pushC(8'h72, 3'b100);
    dataRdEn = 1; cmdRstErr = 1;
    @(negedge clk);
    dataRdEn = 0; cmdRstErr = 0;
    chk("R11", "same-cycle head captured", statVec(), 3'b100);
    flush(); setMr1(8'h00);
  endtask

  task automatic testRts();
    setMr1(8'h80);
    pushC(8'h81, 3'b000); pushC(8'h82, 3'b000);
    pulseStart();
    chk("R5", "start with room keeps rts", rtsOut, 1);
    pushC(8'h83, 3'b000); pushC(8'h84, 3'b000);
    chk("R5", "full without start keeps rts", rtsOut, 1);
    pulseStart();
    chk("R5", "start while full drops rts", rtsOut, 0);
    @(negedge clk);
    chk("R5", "rts stays low while full", rtsOut, 0);
    popC();
    chk("R5", "rts back with free slot", rtsOut, 1);
    pushC(8'h85, 3'b000);
    chk("R5", "refill without start keeps rts", rtsOut, 1);
    setMr1(8'h00);
    pulseStart();
    chk("R4", "rts unaffected when disabled", rtsOut, 1);
    setMr1(8'h80); setMr2(8'h20);
    pulseStart();
    chk("R6", "both enables cancel", rtsOut, 1);
    setMr2(8'h00); setMr1(8'h00);
    flush();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testPointer();
    testFifo();
    testOverrun();
    testIrq();
    testCharMode();
    testBlockMode();
    testRts();
    summary();
    $finish;
  end

endmodule